// File: doc/BRIEF.md
# YCbCr to RGB 5-6-5 Colour-Space Converter

This block turns a stream of luma and colour-difference samples into packed 16-bit RGB pixels for a frame store or display path. Each sample carries an 8-bit unsigned luma value and two signed 8-bit chroma values in two's complement. A sample is taken only on clocks where the pixel qualifier is high. In normal use that qualifier is high on every second clock, so pixels move at half the clock rate. A line-active flag travels with each sample and comes out aligned with its converted pixel.

Processing runs in three stages, and each stage advances only on qualified clocks. The first stage limits luma to 1..254 and each chroma value to -127..126. The second stage applies a fixed-point matrix with 8 fractional bits. It rounds each result and saturates it to 0..255. The third stage reduces red and blue to 5 bits and green to 6 bits using error-feedback dither. The bits dropped from one pixel are added to the next pixel of the same channel. Any sample outside the active line discards that carried error, so each line begins from zero. One active line normally holds 720 qualified samples.

Top module: `ycc2rgb565`

## Requirements
- R1: While reset is high and after it is released, before any qualified sample arrives, `rgb_o`, `line_act_o` and `out_qual_o` are all 0.
- R2: `rgb_o` and `line_act_o` change only at a rising edge on which `pix_en_i` is high.
- R3: A sample presented on qualified edge k appears on `rgb_o` right after qualified edge k+2. Its line flag appears on `line_act_o` on the same edge.
- R4: Luma is limited to 1..254 before conversion. An input of 0 converts as 1, and an input of 255 converts as 254.
- R5: `cb_i` and `cr_i` are two's complement and are limited to -127..126 before conversion.
- R6: With Y, Cb and Cr the limited values, the channel values are R = (256Y + 351Cr + 128) >> 8, G = (256Y − 86Cb − 179Cr + 128) >> 8 and B = (256Y + 443Cb + 128) >> 8. The shift is arithmetic, and each result is saturated to 0..255.
- R7: Red is placed in `rgb_o[15:11]`, green in `rgb_o[10:5]` and blue in `rgb_o[4:0]`.
- R8: For an active sample, each channel adds the residual carried from the previous sample to its 8-bit value and saturates the sum at 255. It outputs the top bits of that sum and carries the dropped bits forward: 3 bits for red and blue, 2 bits for green.
- R9: A sample whose line flag is 0 is converted with a zero residual, and it leaves a zero residual for the next sample.
- R10: `out_qual_o` is high for exactly the clock that follows each qualified edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_en_i | input | 1 | Pixel qualifier, high on clocks that carry a sample |
| line_act_i | input | 1 | Line-active flag of the current sample |
| y_i | input | 8 | Luma, unsigned |
| cb_i | input | 8 | Blue colour difference, two's complement |
| cr_i | input | 8 | Red colour difference, two's complement |
| rgb_o | output | 16 | Packed 5-6-5 pixel |
| line_act_o | output | 1 | Line flag aligned with `rgb_o` |
| out_qual_o | output | 1 | Marks the clock after a fresh output |

## Verification
The bench builds the block with its default parameters: 8-bit samples, 5-6-5 packing, the coefficients 351, 86, 179 and 443, and the limits 1..254 and -127..126. At these widths a few dozen samples reach every clip boundary and the saturation of the matrix. The same samples walk the 3-bit and 2-bit residuals through a full cycle. They also show a carried residual being cut off at a line gap.

// File: rtl/ycc_pkg.sv
package ycc_pkg;

    localparam int PIX_W  = 8;
    localparam int FRAC_W = 8;
    localparam int ACC_W  = 20;
    localparam int N_CH   = 3;

    typedef logic        [PIX_W-1:0] upix_t;
    typedef logic signed [PIX_W-1:0] spix_t;
    typedef logic signed [ACC_W-1:0] acc_t;

    typedef struct packed {
        upix_t y;
        spix_t cb;
        spix_t cr;
        logic  act;
    } ycc_t;

    typedef struct packed {
        upix_t r;
        upix_t g;
        upix_t b;
        logic  act;
    } rgbw_t;

    function automatic upix_t clip_u(upix_t v, upix_t lo, upix_t hi);
        if (v < lo)      return lo;
        else if (v > hi) return hi;
        else             return v;
    endfunction

    function automatic spix_t clip_s(spix_t v, spix_t lo, spix_t hi);
        if (v < lo)      return lo;
        else if (v > hi) return hi;
        else             return v;
    endfunction

    function automatic acc_t widen_u(upix_t v);
        return {{(ACC_W-PIX_W){1'b0}}, v};
    endfunction

    function automatic acc_t widen_s(spix_t v);
        return {{(ACC_W-PIX_W){v[PIX_W-1]}}, v};
    endfunction

    // round to nearest, drop fraction, clamp to the unsigned pixel range
    function automatic upix_t sat_round(acc_t sum);
        acc_t q;
        q = (sum + acc_t'(1 <<< (FRAC_W-1))) >>> FRAC_W;
        if (q < 0)                               return '0;
        else if (q > acc_t'((1 << PIX_W) - 1))   return '1;
        else                                     return q[PIX_W-1:0];
    endfunction

endpackage

// File: rtl/ycc_limit.sv
module ycc_limit
    import ycc_pkg::*;
#(
    parameter int Y_MIN = 1,
    parameter int Y_MAX = 254,
    parameter int C_MIN = -127,
    parameter int C_MAX = 126
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  adv,
    input  logic  act_i,
    input  upix_t y_i,
    input  spix_t cb_i,
    input  spix_t cr_i,
    output ycc_t  smp_o
);

    localparam upix_t YLO = upix_t'(Y_MIN);
    localparam upix_t YHI = upix_t'(Y_MAX);
    localparam spix_t CLO = spix_t'(C_MIN);
    localparam spix_t CHI = spix_t'(C_MAX);

    ycc_t smp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            smp_q <= '0;
        end else if (adv) begin
            smp_q.y   <= clip_u(y_i, YLO, YHI);
            smp_q.cb  <= clip_s(cb_i, CLO, CHI);
            smp_q.cr  <= clip_s(cr_i, CLO, CHI);
            smp_q.act <= act_i;
        end
    end

    assign smp_o = smp_q;

    // R4
    y_range_chk: assert property (@(posedge clk) disable iff (rst)
        adv |=> (smp_q.y >= YLO && smp_q.y <= YHI));

    // R5
    c_range_chk: assert property (@(posedge clk) disable iff (rst)
        adv |=> (smp_q.cb >= CLO && smp_q.cb <= CHI &&
                 smp_q.cr >= CLO && smp_q.cr <= CHI));

endmodule

// File: rtl/ycc_matrix.sv
module ycc_matrix
    import ycc_pkg::*;
#(
    parameter int K_RCR = 351,
    parameter int K_GCB = 86,
    parameter int K_GCR = 179,
    parameter int K_BCB = 443
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  adv,
    input  ycc_t  smp_i,
    output rgbw_t pix_o
);

    localparam acc_t KR  = acc_t'(K_RCR);
    localparam acc_t KGB = acc_t'(K_GCB);
    localparam acc_t KGR = acc_t'(K_GCR);
    localparam acc_t KB  = acc_t'(K_BCB);

    acc_t  y_sc, cb_w, cr_w;
    acc_t  r_sum, g_sum, b_sum;
    rgbw_t pix_q;

    always_comb begin
        y_sc  = widen_u(smp_i.y) <<< FRAC_W;
        cb_w  = widen_s(smp_i.cb);
        cr_w  = widen_s(smp_i.cr);
        r_sum = y_sc + KR * cr_w;
        g_sum = y_sc - KGB * cb_w - KGR * cr_w;
        b_sum = y_sc + KB * cb_w;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_q <= '0;
        end else if (adv) begin
            pix_q.r   <= sat_round(r_sum);
            pix_q.g   <= sat_round(g_sum);
            pix_q.b   <= sat_round(b_sum);
            pix_q.act <= smp_i.act;
        end
    end

    assign pix_o = pix_q;

endmodule

// File: rtl/dither_chan.sv
module dither_chan #(
    parameter int IN_W  = 8,
    parameter int OUT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic             act,
    input  logic [IN_W-1:0]  din,
    output logic [OUT_W-1:0] dout
);

    localparam int RES_W = IN_W - OUT_W;

    logic [RES_W-1:0] res_q;
    logic [RES_W-1:0] res_use;
    logic [IN_W:0]    sum;
    logic [IN_W-1:0]  sat;
    logic [OUT_W-1:0] dout_q;

    always_comb begin
        res_use = act ? res_q : '0;
        sum     = {1'b0, din} + {{(OUT_W+1){1'b0}}, res_use};
        sat     = sum[IN_W] ? '1 : sum[IN_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q  <= '0;
            dout_q <= '0;
        end else if (adv) begin
            dout_q <= sat[IN_W-1 -: OUT_W];
            res_q  <= act ? sat[RES_W-1:0] : '0;
        end
    end

    assign dout = dout_q;

    // R8
    full_scale_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && act && din == '1) |=> (dout == '1));

    // R9
    gap_trunc_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && !act) |=> (dout == $past(din[IN_W-1 -: OUT_W])));

endmodule

// File: rtl/rgb_dither.sv
module rgb_dither
    import ycc_pkg::*;
#(
    parameter int R_BITS = 5,
    parameter int G_BITS = 6,
    parameter int B_BITS = 5,
    localparam int TOT_W = R_BITS + G_BITS + B_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  rgbw_t            pix_i,
    output logic [TOT_W-1:0] rgb_o,
    output logic             act_o
);

    logic act_q;

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        localparam int OW  = (ch == 0) ? R_BITS : ((ch == 1) ? G_BITS : B_BITS);
        localparam int LSB = (ch == 0) ? (G_BITS + B_BITS) : ((ch == 1) ? B_BITS : 0);
        upix_t        din;
        logic [OW-1:0] dq;

        assign din = (ch == 0) ? pix_i.r : ((ch == 1) ? pix_i.g : pix_i.b);

        dither_chan #(.IN_W(PIX_W), .OUT_W(OW)) u_chan (
            .clk  (clk),
            .rst  (rst),
            .adv  (adv),
            .act  (pix_i.act),
            .din  (din),
            .dout (dq)
        );

        assign rgb_o[LSB +: OW] = dq;
    end

    always_ff @(posedge clk) begin
        if (rst)      act_q <= 1'b0;
        else if (adv) act_q <= pix_i.act;
    end

    assign act_o = act_q;

endmodule

// File: rtl/ycc2rgb565.sv
module ycc2rgb565
    import ycc_pkg::*;
#(
    parameter int K_RCR  = 351,
    parameter int K_GCB  = 86,
    parameter int K_GCR  = 179,
    parameter int K_BCB  = 443,
    parameter int Y_MIN  = 1,
    parameter int Y_MAX  = 254,
    parameter int C_MIN  = -127,
    parameter int C_MAX  = 126,
    parameter int R_BITS = 5,
    parameter int G_BITS = 6,
    parameter int B_BITS = 5,
    localparam int TOT_W = R_BITS + G_BITS + B_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pix_en_i,
    input  logic             line_act_i,
    input  logic [7:0]       y_i,
    input  logic [7:0]       cb_i,
    input  logic [7:0]       cr_i,
    output logic [TOT_W-1:0] rgb_o,
    output logic             line_act_o,
    output logic             out_qual_o
);

    ycc_t  smp;
    rgbw_t pix;
    logic  qual_q;

    ycc_limit #(
        .Y_MIN(Y_MIN), .Y_MAX(Y_MAX), .C_MIN(C_MIN), .C_MAX(C_MAX)
    ) u_limit (
        .clk   (clk),
        .rst   (rst),
        .adv   (pix_en_i),
        .act_i (line_act_i),
        .y_i   (upix_t'(y_i)),
        .cb_i  (spix_t'(cb_i)),
        .cr_i  (spix_t'(cr_i)),
        .smp_o (smp)
    );

    ycc_matrix #(
        .K_RCR(K_RCR), .K_GCB(K_GCB), .K_GCR(K_GCR), .K_BCB(K_BCB)
    ) u_matrix (
        .clk   (clk),
        .rst   (rst),
        .adv   (pix_en_i),
        .smp_i (smp),
        .pix_o (pix)
    );

    rgb_dither #(
        .R_BITS(R_BITS), .G_BITS(G_BITS), .B_BITS(B_BITS)
    ) u_dither (
        .clk   (clk),
        .rst   (rst),
        .adv   (pix_en_i),
        .pix_i (pix),
        .rgb_o (rgb_o),
        .act_o (line_act_o)
    );

    always_ff @(posedge clk) begin
        if (rst) qual_q <= 1'b0;
        else     qual_q <= pix_en_i;
    end

    assign out_qual_o = qual_q;

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !pix_en_i |=> ($stable(rgb_o) && $stable(line_act_o)));

    // R10
    qual_mark_chk: assert property (@(posedge clk) disable iff (rst)
        pix_en_i |=> out_qual_o);

    // R10
    qual_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !pix_en_i |=> !out_qual_o);

endmodule

// File: tb/ycc2rgb565_tb_top.sv
`timescale 1ns/1ps
module ycc2rgb565_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pix_en_i = 1'b0;
    logic        line_act_i = 1'b0;
    logic [7:0]  y_i = '0;
    logic [7:0]  cb_i = '0;
    logic [7:0]  cr_i = '0;
    logic [15:0] rgb_o;
    logic        line_act_o;
    logic        out_qual_o;

    int total = 0;
    int bad   = 0;
    int n_sent = 0;
    int er = 0, eg = 0, eb = 0;
    logic [15:0] exp_rgb [0:511];
    logic        exp_act [0:511];
    string       exp_tag [0:511];

    always #2 clk = ~clk;

    ycc2rgb565 dut_i (
        .clk(clk), .rst(rst), .pix_en_i(pix_en_i), .line_act_i(line_act_i),
        .y_i(y_i), .cb_i(cb_i), .cr_i(cr_i),
        .rgb_o(rgb_o), .line_act_o(line_act_o), .out_qual_o(out_qual_o)
    );

    task automatic check(input string tag, input int act, input int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic int clampi(int v, int lo, int hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    // reference model built from R4..R9
    task automatic model(input int y, input int cb, input int cr, input bit act,
                         input string tag);
        int yl, cbl, crl, r, g, b, sr, sg, sb;
        yl  = clampi(y, 1, 254);
        cbl = clampi(cb, -127, 126);
        crl = clampi(cr, -127, 126);
        r = clampi((yl*256 + 351*crl + 128) >>> 8, 0, 255);
        g = clampi((yl*256 - 86*cbl - 179*crl + 128) >>> 8, 0, 255);
        b = clampi((yl*256 + 443*cbl + 128) >>> 8, 0, 255);
        sr = clampi(r + (act ? er : 0), 0, 255);
        sg = clampi(g + (act ? eg : 0), 0, 255);
        sb = clampi(b + (act ? eb : 0), 0, 255);
        er = act ? (sr & 7) : 0;
        eg = act ? (sg & 3) : 0;
        eb = act ? (sb & 7) : 0;
        exp_rgb[n_sent] = 16'(((sr >> 3) << 11) | ((sg >> 2) << 5) | (sb >> 3));
        exp_act[n_sent] = act;
        exp_tag[n_sent] = tag;
    endtask

    // one qualified clock followed by one idle clock
    task automatic send(input int y, input int cb, input int cr, input bit act,
                        input string tag);
        logic [15:0] held;
        int k;
        model(y, cb, cr, act, tag);
        k = n_sent;
        n_sent++;
        @(negedge clk);
        y_i = 8'(y); cb_i = 8'(cb); cr_i = 8'(cr);
        line_act_i = act; pix_en_i = 1'b1;
        @(negedge clk);
        pix_en_i = 1'b0;
        check("R10 qual after qualified edge", int'(out_qual_o), 1);
        if (k >= 2) begin
            check(exp_tag[k-2], int'(rgb_o), int'(exp_rgb[k-2]));
            check("R3 line flag latency", int'(line_act_o), int'(exp_act[k-2]));
        end
        held = rgb_o;
        y_i = 8'hA5; cb_i = 8'h5A; cr_i = 8'h81; line_act_i = ~act;
        @(negedge clk);
        check("R2 hold on idle clock", int'(rgb_o), int'(held));
        check("R10 qual low on idle clock", int'(out_qual_o), 0);
    endtask

    task automatic flush();
        send(0, 0, 0, 1'b0, "R9 flush");
        send(0, 0, 0, 1'b0, "R9 flush");
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 rgb in reset", int'(rgb_o), 0);
        check("R1 line flag in reset", int'(line_act_o), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 rgb after reset", int'(rgb_o), 0);
        check("R1 line flag after reset", int'(line_act_o), 0);
        check("R1 qual after reset", int'(out_qual_o), 0);
    endtask

    task automatic t_gray();
        send(235, 0, 0, 1'b0, "R7 gray pack");
        flush();
        check("R7 packed white-ish 235", int'(rgb_o), 16'hEF5D);
        for (int i = 0; i < 6; i++) send(16 + i*40, 0, 0, 1'b1, "R6 gray ramp");
    endtask

    task automatic t_colour();
        send(120, 60, -40, 1'b1, "R6 colour a");
        send(80, -100, 90, 1'b1, "R6 colour b");
        send(200, 110, 110, 1'b1, "R6 saturate high");
        send(20, 120, -120, 1'b1, "R6 saturate low");
        send(150, -30, -70, 1'b1, "R6 colour c");
    endtask

    task automatic t_ylimit();
        flush();
        for (int i = 0; i < 10; i++) send(0, 0, 0, 1'b1, "R4 luma floor");
        for (int i = 0; i < 4; i++) send(255, 0, 0, 1'b1, "R4 luma ceiling");
    endtask

    task automatic t_climit();
        flush();
        send(200, 0, -128, 1'b0, "R5 cr floor");
        send(200, 0, 127, 1'b0, "R5 cr ceiling");
        send(100, -128, 0, 1'b0, "R5 cb floor");
        send(100, 127, 0, 1'b0, "R5 cb ceiling");
    endtask

    task automatic t_dither();
        flush();
        for (int i = 0; i < 9; i++) send(100, 0, 0, 1'b1, "R8 residual carry");
        for (int i = 0; i < 5; i++) send(253, 0, 0, 1'b1, "R8 sum saturation");
        send(100, 0, 0, 1'b0, "R9 gap truncation");
        send(100, 0, 0, 1'b0, "R9 gap truncation");
        for (int i = 0; i < 4; i++) send(101, 3, -2, 1'b1, "R9 new line from zero");
    endtask

    task automatic t_line();
        send(50, 10, 10, 1'b1, "R3 line edge");
        send(60, 10, 10, 1'b0, "R3 line edge");
        send(70, 10, 10, 1'b1, "R3 line edge");
        send(80, 10, 10, 1'b1, "R3 line edge");
        send(90, 10, 10, 1'b0, "R3 line edge");
        flush();
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #800000;
        total++;
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        t_reset();
        t_gray();
        t_colour();
        t_ylimit();
        t_climit();
        t_dither();
        t_line();
        finish_run();
    end

endmodule